// File: doc/BRIEF.md
# Refresh Scheduler and Power-Up Sequencer for an Asynchronous DRAM

This block keeps an asynchronous DRAM alive. It counts system clocks and owes one refresh each time a fixed interval expires. It asks the access sequencer for the memory bus and runs one refresh cycle per grant. Each refresh is a column-strobe-before-row-strobe cycle. Both column strobes fall first, the row strobe follows, and the DRAM's own row counter picks the row. The write enable and output enable stay inactive, and the data bus is never driven. No address is presented.

After reset the block keeps every strobe inactive for a long pause. It then runs a set number of initialization cycles without asking for the bus, and only then raises a ready flag. If the access sequencer withholds the grant, owed refreshes pile up to a parameterized limit. When the grant arrives, all of them are issued back to back.

Top module: `dram_refresh_seq`

## Requirements
- R1: Once ready, with the grant held high, row-strobe falling edges are spaced exactly REFI_CYCLES clocks apart.
- R2: In every cycle, both column strobes fall together exactly TCSR_CYCLES clocks before the row strobe falls. They stay low for as long as the row strobe is low.
- R3: The row strobe stays low for exactly TRAS_CYCLES clocks. The column strobes rise on the same clock as the row strobe.
- R4: Between cycles the row strobe stays high for at least TRP_CYCLES clocks. Back-to-back cycles have their row-strobe falling edges TCSR_CYCLES+TRAS_CYCLES+TRP_CYCLES+1 clocks apart.
- R5: Write enable and output enable (active low) are always 1, and the data-drive enable is always 0.
- R6: While reset is applied, all strobes are high, and bus_req and mem_ready are 0.
- R7: After reset, no strobe goes low during the first PAUSE_CYCLES clocks.
- R8: After the pause, exactly INIT_CYCLES strobe cycles run with no grant needed. Then mem_ready rises and stays high until reset.
- R9: bus_req is 0 before ready. After ready, it rises when a refresh is owed and stays high until a granted cycle completes. No cycle starts while the grant is low.
- R10: The count of owed refreshes saturates at MAX_OWED. After a long withheld grant, exactly MAX_OWED cycles run back to back, and then bus_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_gnt | input | 1 | Bus grant from the access sequencer |
| bus_req | output | 1 | Request for the memory bus |
| row_stb_n | output | 1 | Row strobe, active low |
| col_stb_lo_n | output | 1 | Column strobe for the low byte, active low |
| col_stb_hi_n | output | 1 | Column strobe for the high byte, active low |
| wr_en_n | output | 1 | Write enable, active low, held inactive |
| out_en_n | output | 1 | Output enable, active low, held inactive |
| data_drive | output | 1 | Data bus drive enable, held off |
| mem_ready | output | 1 | Initialization done, memory usable |

## Verification
The hardest state to reach is a saturated backlog, where more intervals have expired than the owed count can hold. From the ports, this state shows only as a burst of fixed length once the grant returns. The bench withholds the grant for several refresh intervals to get there. It then releases the grant at a known phase of the interval, counted from the rise of mem_ready. This keeps a fresh interval from landing inside the burst, so exactly MAX_OWED back-to-back cycles are expected. A shorter withheld grant then shows that the request holds without any strobe activity until the grant comes.

// File: rtl/dref_pkg.sv
// Shared state encodings for the refresh scheduler.
// Assumes: the encodings are local to this block and not decoded elsewhere.
package dref_pkg;
    typedef enum logic [1:0] {
        CY_IDLE,
        CY_SETUP,
        CY_ACTIVE,
        CY_PRE
    } cyc_state_t;

    typedef enum logic [1:0] {
        PU_PAUSE,
        PU_INIT,
        PU_READY
    } pu_state_t;
endpackage

// File: rtl/dref_tick.sv
// Interval timer: pulses tick for one clock every PERIOD clocks while en is high.
// Assumes: PERIOD >= 2, and the count restarts from zero whenever en is low.
module dref_tick #(
    parameter int PERIOD = 1900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    // Free-running interval count, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    // R1: two interval pulses never occur on adjacent clocks
    a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dref_debt.sv
// Owed-refresh counter: adds one per interval pulse, removes one per finished cycle.
// Assumes: dec only occurs while the count is non-zero; the count saturates at MAX.
module dref_debt #(
    parameter int MAX = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc,
    input  logic                       dec,
    output logic [$clog2(MAX+1)-1:0]   owed
);
    localparam int W = $clog2(MAX + 1);
    localparam logic [W-1:0] TOP = W'(MAX);

    // Saturating up/down count of refreshes not yet issued.
    always_ff @(posedge clk) begin
        if (!rst_n) owed <= '0;
        else if (inc && !dec && owed != TOP) owed <= owed + 1'b1;
        else if (dec && !inc && owed != '0) owed <= owed - 1'b1;
    end

    // R10: a full count stays full when another interval expires
    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (owed == TOP && inc && !dec) |=> owed == TOP);
    // R10: a finished cycle is never credited against an empty count
    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> owed != '0);
endmodule

// File: rtl/dref_strobe.sv
// Strobe engine: runs one column-before-row cycle per start pulse.
// Phases are column setup, row active and precharge; done pulses on the last precharge clock.
// Assumes: start is only honoured in idle; every timing parameter is >= 1.
module dref_strobe
    import dref_pkg::*;
#(
    parameter int TCSR = 2,
    parameter int TRAS = 8,
    parameter int TRP  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic done,
    output logic row_n,
    output logic col_n
);
    localparam int TMAX = (TCSR > TRAS) ? ((TCSR > TRP) ? TCSR : TRP)
                                        : ((TRAS > TRP) ? TRAS : TRP);
    localparam int CW = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LD_CSR = CW'(TCSR - 1);
    localparam logic [CW-1:0] LD_RAS = CW'(TRAS - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(TRP - 1);

    cyc_state_t    st;
    logic [CW-1:0] cnt;

    assign idle  = (st == CY_IDLE);
    assign done  = (st == CY_PRE) && (cnt == '0);
    assign row_n = (st != CY_ACTIVE);
    assign col_n = !((st == CY_SETUP) || (st == CY_ACTIVE));

    // Phase sequencing with a per-phase down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CY_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                CY_IDLE:   if (start) begin st <= CY_SETUP; cnt <= LD_CSR; end
                CY_SETUP:  if (cnt == '0) begin st <= CY_ACTIVE; cnt <= LD_RAS; end
                           else cnt <= cnt - 1'b1;
                CY_ACTIVE: if (cnt == '0) begin st <= CY_PRE; cnt <= LD_RP; end
                           else cnt <= cnt - 1'b1;
                CY_PRE:    if (cnt == '0) st <= CY_IDLE;
                           else cnt <= cnt - 1'b1;
                default:   st <= CY_IDLE;
            endcase
        end
    end

    // Checker-only run lengths of the row strobe at each level.
    logic [15:0] low_run, high_run;
    logic        seen_low;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= '0;
            seen_low <= 1'b0;
        end else begin
            low_run  <= row_n ? '0 : ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1);
            high_run <= !row_n ? '0 : ((high_run == 16'hFFFF) ? high_run : high_run + 1'b1);
            if (!row_n) seen_low <= 1'b1;
        end
    end

    // R2: the column strobe was already low one clock before the row strobe fell
    a_r2_col_leads_row: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(row_n) |-> (!col_n && $past(!col_n)));
    // R2: the column strobe is held low under the row strobe
    a_r2_col_held: assert property (@(posedge clk) disable iff (!rst_n)
        !row_n |-> !col_n);
    // R3: the row strobe met its minimum low time before rising
    a_r3_row_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_n) |-> low_run >= 16'(TRAS));
    // R4: precharge was honoured before the next row strobe
    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(row_n) && seen_low) |-> high_run >= 16'(TRP));
endmodule

// File: rtl/dram_refresh_seq.sv
// Refresh scheduler and power-up sequencer for an asynchronous DRAM.
// After reset: a strobe-free pause, then INIT_CYCLES cycles without a bus grant, then ready.
// When ready: one refresh is owed per REFI_CYCLES, and each is run after a granted bus request.
// Assumes: the access sequencer does not use the bus until mem_ready; the grant is sampled only while bus_req is high.
module dram_refresh_seq
    import dref_pkg::*;
#(
    parameter int PAUSE_CYCLES = 25000,
    parameter int INIT_CYCLES  = 8,
    parameter int REFI_CYCLES  = 1900,
    parameter int TCSR_CYCLES  = 2,
    parameter int TRAS_CYCLES  = 8,
    parameter int TRP_CYCLES   = 6,
    parameter int MAX_OWED     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    output logic bus_req,
    output logic row_stb_n,
    output logic col_stb_lo_n,
    output logic col_stb_hi_n,
    output logic wr_en_n,
    output logic out_en_n,
    output logic data_drive,
    output logic mem_ready
);
    localparam int PW = $clog2(PAUSE_CYCLES + 1);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam int DW = $clog2(MAX_OWED + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYCLES - 1);
    localparam logic [IW-1:0] INIT_LAST  = IW'(INIT_CYCLES - 1);

    pu_state_t     pu;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_cnt;
    logic          ready_q;
    logic          tick, eng_idle, eng_done, eng_start, row_n, col_n;
    logic [DW-1:0] owed;

    assign ready_q   = (pu == PU_READY);
    assign eng_start = eng_idle && ((pu == PU_INIT) ||
                                    (ready_q && owed != '0 && bus_gnt));

    // Power-up progression: pause, initialization cycles, ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu        <= PU_PAUSE;
            pause_cnt <= '0;
            init_cnt  <= '0;
        end else begin
            case (pu)
                PU_PAUSE: if (pause_cnt == PAUSE_LAST) pu <= PU_INIT;
                          else pause_cnt <= pause_cnt + 1'b1;
                PU_INIT:  if (eng_done) begin
                              if (init_cnt == INIT_LAST) pu <= PU_READY;
                              else init_cnt <= init_cnt + 1'b1;
                          end
                default:  pu <= PU_READY;
            endcase
        end
    end

    dref_tick #(.PERIOD(REFI_CYCLES)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(ready_q), .tick(tick)
    );

    dref_debt #(.MAX(MAX_OWED)) u_debt (
        .clk(clk), .rst_n(rst_n), .inc(tick), .dec(eng_done && ready_q), .owed(owed)
    );

    dref_strobe #(.TCSR(TCSR_CYCLES), .TRAS(TRAS_CYCLES), .TRP(TRP_CYCLES)) u_stb (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .idle(eng_idle),
        .done(eng_done), .row_n(row_n), .col_n(col_n)
    );

    assign bus_req      = ready_q && ((owed != '0) || !eng_idle);
    assign row_stb_n    = row_n;
    assign col_stb_lo_n = col_n;
    assign col_stb_hi_n = col_n;
    assign wr_en_n      = 1'b1;
    assign out_en_n     = 1'b1;
    assign data_drive   = 1'b0;
    assign mem_ready    = ready_q;

    // R7: all strobes idle through the power-up pause
    a_r7_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (pu == PU_PAUSE) |-> (row_stb_n && col_stb_lo_n && col_stb_hi_n));
    // R8: ready never drops once raised
    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |=> mem_ready);
    // R9: an ungranted request is held, and no cycle begins without the grant
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && eng_idle) |=> (bus_req && eng_idle));
    // R9: no request before initialization completes
    a_r9_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> !bus_req);
endmodule

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
    localparam int PAUSE = 20;
    localparam int INIT  = 8;
    localparam int REFI  = 50;
    localparam int TCSR  = 2;
    localparam int TRAS  = 4;
    localparam int TRP   = 3;
    localparam int MAXO  = 3;
    localparam int B2B   = TCSR + TRAS + TRP + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_gnt = 1'b0;
    logic bus_req, row_stb_n, col_stb_lo_n, col_stb_hi_n, wr_en_n, out_en_n, data_drive, mem_ready;

    always #4 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYCLES(PAUSE), .INIT_CYCLES(INIT), .REFI_CYCLES(REFI),
        .TCSR_CYCLES(TCSR), .TRAS_CYCLES(TRAS), .TRP_CYCLES(TRP), .MAX_OWED(MAXO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .row_stb_n(row_stb_n), .col_stb_lo_n(col_stb_lo_n), .col_stb_hi_n(col_stb_hi_n),
        .wr_en_n(wr_en_n), .out_en_n(out_en_n), .data_drive(data_drive), .mem_ready(mem_ready)
    );

    int n_checks = 0, n_fail = 0;
    int phase = 0;
    int cyc = 0, ready_cyc = 0;
    int col_run = 0, low_run = 0, high_run = 0;
    int falls_total = 0, falls_pre_ready = 0, first_fall = -1;
    int last_fall = -1, last_fall_phase = -1;
    int falls_ph[0:5];
    bit prev_row = 1'b1, was_ready = 1'b0, seen_low = 1'b0;
    int bad_r5 = 0, req_early = 0, col_mismatch = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor at the falling edge: strobe shapes, spacing and static outputs.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (mem_ready) ready_cyc++;
            if (!wr_en_n || !out_en_n || data_drive) bad_r5++;
            if (!mem_ready && bus_req) req_early++;
            if (col_stb_lo_n != col_stb_hi_n) col_mismatch++;
            if (!col_stb_lo_n) col_run++; else col_run = 0;
            if (prev_row && !row_stb_n) begin
                // falling edge of the row strobe
                check(col_run == TCSR + 1, "R2 column lead", col_run - 1, TCSR);
                if (seen_low)
                    check(high_run >= TRP, "R4 precharge gap", high_run, TRP);
                if (first_fall < 0) first_fall = cyc;
                if (!mem_ready) falls_pre_ready++;
                falls_ph[phase]++;
                if (phase == 1 && last_fall_phase == 1)
                    check(cyc - last_fall == REFI, "R1 interval", cyc - last_fall, REFI);
                if (phase == 3 && last_fall_phase == 3)
                    check(cyc - last_fall == B2B, "R4 back-to-back", cyc - last_fall, B2B);
                last_fall = cyc;
                last_fall_phase = phase;
                falls_total++;
                low_run = 0;
                seen_low = 1'b1;
            end
            if (!prev_row && row_stb_n) begin
                check(low_run == TRAS, "R3 row low width", low_run, TRAS);
                check(col_stb_lo_n == 1'b1, "R3 column rises with row", col_stb_lo_n, 1);
                high_run = 0;
            end
            if (!row_stb_n) begin
                low_run++;
                if (col_stb_lo_n) check(1'b0, "R2 column held under row", 1, 0);
            end else high_run++;
            if (was_ready && !mem_ready) check(1'b0, "R8 ready sticky", 0, 1);
            was_ready = mem_ready;
            prev_row = row_stb_n;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_phase(input int m);
        for (int i = 0; i < REFI + 2; i++) begin
            if (ready_cyc % REFI == m) break;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 6; i++) falls_ph[i] = 0;
        // R6: state under reset
        wait_cycles(5);
        check(row_stb_n && col_stb_lo_n && col_stb_hi_n, "R6 strobes high in reset",
              {row_stb_n, col_stb_lo_n, col_stb_hi_n}, 7);
        check(!bus_req, "R6 bus_req low in reset", bus_req, 0);
        check(!mem_ready, "R6 mem_ready low in reset", mem_ready, 0);
        rst_n = 1'b1;

        // R7, R8: pause then initialization without any grant
        for (int i = 0; i < 2000; i++) begin
            if (mem_ready) break;
            @(negedge clk);
        end
        check(mem_ready, "R8 ready reached", mem_ready, 1);
        check(first_fall > PAUSE, "R7 pause before first strobe", first_fall, PAUSE + 1);
        check(falls_pre_ready == INIT, "R8 init cycle count", falls_pre_ready, INIT);
        check(req_early == 0, "R9 no request before ready", req_early, 0);

        // R1: steady refresh with the grant held
        phase = 1;
        bus_gnt = 1'b1;
        wait_cycles(6 * REFI);
        check(falls_ph[1] >= 5, "R1 steady refresh count", falls_ph[1], 6);

        // R10: withhold the grant long enough to saturate the backlog
        wait_phase(20);
        phase = 2;
        bus_gnt = 1'b0;
        wait_cycles(5 * REFI);
        wait_cycles(1);
        wait_phase(8);
        check(falls_ph[2] == 0, "R9 no cycle without grant", falls_ph[2], 0);
        check(bus_req, "R9 request held while ungranted", bus_req, 1);
        phase = 3;
        bus_gnt = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!bus_req) break;
        end
        check(!bus_req, "R10 request drops after burst", bus_req, 0);
        check(falls_ph[3] == MAXO, "R10 burst length at saturation", falls_ph[3], MAXO);

        // R9: a short withheld grant after a fresh interval
        phase = 4;
        bus_gnt = 1'b0;
        for (int i = 0; i < 2 * REFI; i++) begin
            if (bus_req) break;
            @(negedge clk);
        end
        check(bus_req, "R9 request on owed refresh", bus_req, 1);
        wait_cycles(7);
        check(falls_ph[4] == 0, "R9 no strobe before grant", falls_ph[4], 0);
        check(bus_req, "R9 request still held", bus_req, 1);
        bus_gnt = 1'b1;
        wait_cycles(TCSR + 3);
        check(falls_ph[4] == 1, "R9 cycle follows grant", falls_ph[4], 1);
        wait_cycles(TRAS + TRP + 3);
        check(!bus_req, "R9 request released after cycle", bus_req, 0);

        check(bad_r5 == 0, "R5 enables inactive, bus undriven", bad_r5, 0);
        check(col_mismatch == 0, "R2 both column strobes identical", col_mismatch, 0);
        check(mem_ready, "R8 ready still high", mem_ready, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule